// File: doc/BRIEF.md
# Periodic Interrupt and Square-Wave Generator

This block runs from a time-base clock and counts it with one binary divider chain. The chain gives a one-cycle tick once per second and a rate-selectable periodic event. The same event drives a square-wave pin. A two-bit control picks one of three time-base frequencies: 4.194304 MHz, 1.048576 MHz or 32.768 kHz. A hold bit keeps the chain parked at its half-second point, so the first tick after release comes half a second later.

The periodic event sets one of three interrupt flags. The other two flags are set by alarm and end-of-update pulses that neighbouring blocks deliver. Each flag has its own enable. Any flag that is set with its enable set pulls the active-low request pin low and sets a summary bit. A read strobe on the flag register clears every flag, which releases the request. A clock output gives the time base itself or the time base divided by four.

Top module: `periodic_irq_gen`

## Requirements
- R1: While reset (rst_n low, sampled on the clock edge) is applied, flags reads 0, irq_n is 1, and sqw and tick_1hz are 0.
- R2: base_sel[1:0] picks the time-base size: 0 gives 2^22 cycles per second, 1 gives 2^20, and 2 or 3 gives 2^15. While the chain runs, tick_1hz is high for one cycle in every 2^L cycles, where 2^L is the selected size.
- R3: While div_hold is 1, the chain is parked at 2^(L-1). No tick appears, the periodic flag does not set and sqw is 0. After release, the first tick follows the 2^(L-1)-th running clock edge.
- R4: Rate codes 3 to 15 give a periodic event every 2^(L-16+code) cycles, which is 2^(16-code) Hz of real time. Each event sets the periodic flag, flags[2].
- R5: Rate codes 1 and 2 follow the same formula for the two fast bases. With the 2^15 base, codes 1 and 2 act as codes 8 and 9 (256 Hz and 128 Hz).
- R6: Rate code 0 stops the periodic flag from setting and holds sqw at 0.
- R7: With sq_en set and a nonzero rate, sqw is 0 for the first half of each period and 1 for the second half. It falls on the same edge that sets the periodic flag. With sq_en clear, sqw is 0.
- R8: An alarm_pulse sets flags[1] and an update_pulse sets flags[0]. All three flags set whatever their enables are, and a flag stays set until it is read.
- R9: flags[3] is 1, and irq_n is 0, exactly while some flag is set with its enable set (pie for flags[2], aie for flags[1], uie for flags[0]).
- R10: A flag_rd strobe on a clock edge clears all three flags. An event on that same edge still leaves its flag set.
- R11: With ck_div4 at 0, ckout follows clk. With ck_div4 at 1, ckout is bit 1 of a two-bit count of clock edges since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_sel | input | 2 | Time-base frequency select |
| div_hold | input | 1 | Holds the divider chain parked |
| rate_sel | input | 4 | Periodic rate code, 0 = off |
| sq_en | input | 1 | Square-wave enable |
| pie | input | 1 | Periodic interrupt enable |
| aie | input | 1 | Alarm interrupt enable |
| uie | input | 1 | Update-end interrupt enable |
| alarm_pulse | input | 1 | Alarm event, one cycle |
| update_pulse | input | 1 | End-of-update event, one cycle |
| flag_rd | input | 1 | Flag register read strobe, clears flags |
| ck_div4 | input | 1 | Clock output divide-by-4 select |
| sqw | output | 1 | Square-wave output |
| irq_n | output | 1 | Active-low interrupt request |
| flags | output | 4 | {summary, periodic, alarm, update} |
| tick_1hz | output | 1 | One-cycle once-per-second tick |
| ckout | output | 1 | Time base divided by 1 or 4 |

## Verification
The bench uses the default sizes, 2^22, 2^20 and 2^15 cycles per second. With the 32.768 kHz base, a full second takes only 32768 cycles, so the run covers the delayed first tick after release, a following tick and the slowest rate code. The two fast bases are run only with short rate codes. There the aliased codes 1 and 2 and the base-dependent tap shift can be checked against the slow base within a few thousand cycles.

// File: rtl/psq_pkg.sv
// Package: shared helpers for the periodic generator.
// Assumes time-base sizes are powers of two given as log2 values.
package psq_pkg;

    // Largest of three log2 sizes, used to size the divider chain.
    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Divider tap exponent for a rate code: period = 2^exp cycles.
    function automatic int unsigned tap_exp(int unsigned l2, logic [3:0] code, logic slow);
        int e;
        e = int'(l2) - 16 + int'(code);
        if (slow && code < 4'd3) e = e + 7;
        if (e > int'(l2) - 1) e = int'(l2) - 1;
        if (e < 1) e = 1;
        return int'(e);
    endfunction

endpackage

// File: rtl/psq_divider.sv
// Module: binary divider chain with hold and once-per-second tick.
// Assumes the three log2 sizes are at least 2 and CW covers the largest.
module psq_divider #(
    parameter int unsigned L_HI  = 22,
    parameter int unsigned L_MID = 20,
    parameter int unsigned L_LO  = 15,
    parameter int unsigned CW    = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic [1:0]    base_sel,
    output logic [CW-1:0] cnt,
    output logic [5:0]    l_cur,
    output logic          slow,
    output logic          run,
    output logic          tick
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [CW-1:0] half_pt;
    logic [CW-1:0] l_mask;
    logic          wrap;

    // Decode the time-base size and the chain's parking point.
    always_comb begin
        case (base_sel)
            2'd0:    l_cur = 6'(L_HI);
            2'd1:    l_cur = 6'(L_MID);
            default: l_cur = 6'(L_LO);
        endcase
        slow    = base_sel[1];
        run     = ~hold;
        half_pt = ONE << (l_cur - 6'd1);
        l_mask  = (ONE << l_cur) - ONE;
        wrap    = (cnt & l_mask) == l_mask;
    end

    // Advance the chain, or park it at half a second, and register the tick.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt  <= half_pt;
            tick <= 1'b0;
        end else begin
            cnt  <= cnt + ONE;
            tick <= wrap;
        end
    end

    // R2: the tick is a single-cycle pulse.
    a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    // R3: a held chain never produces a tick.
    a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !tick);

endmodule

// File: rtl/psq_rate_tap.sv
// Module: selects the periodic tap of the chain and forms the square wave.
// Assumes cnt is the running divider value and run is high while it advances.
module psq_rate_tap #(
    parameter int unsigned CW = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] cnt,
    input  logic [5:0]    l_cur,
    input  logic          slow,
    input  logic [3:0]    rate_sel,
    input  logic          sq_en,
    output logic          per_evt,
    output logic          sqw
);
    import psq_pkg::*;

    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [5:0]    e_amt;
    logic [CW-1:0] e_mask;
    logic [CW-1:0] cnt_nxt;
    logic          sq_bit;
    logic          rate_on;

    // Find the tap, detect the end of a period and the next square-wave level.
    always_comb begin
        e_amt   = 6'(tap_exp(32'(l_cur), rate_sel, slow));
        e_mask  = (ONE << e_amt) - ONE;
        rate_on = rate_sel != 4'd0;
        per_evt = run && rate_on && ((cnt & e_mask) == e_mask);
        cnt_nxt = cnt + ONE;
        sq_bit  = |((cnt_nxt >> (e_amt - 6'd1)) & ONE);
    end

    // Register the square wave, forced low when disabled or held.
    always_ff @(posedge clk) begin
        if (!rst_n) sqw <= 1'b0;
        else        sqw <= run && sq_en && rate_on && sq_bit;
    end

    // R7: the square wave falls on the edge that ends a period.
    a_r7_fall_at_event: assert property (@(posedge clk) disable iff (!rst_n)
        per_evt |=> !sqw);
    // R6: rate code zero keeps the square wave low.
    a_r6_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == 4'd0) |=> !sqw);

endmodule

// File: rtl/psq_irq.sv
// Module: three sticky interrupt flags, masking and clear-on-read.
// Assumes event inputs are single-cycle pulses in the clk domain.
module psq_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       per_evt,
    input  logic       alarm_evt,
    input  logic       upd_evt,
    input  logic       rd,
    input  logic       pie,
    input  logic       aie,
    input  logic       uie,
    output logic [3:0] flags,
    output logic       irq_n
);
    logic pf_q, af_q, uf_q, sum;

    // Set flags on events, clear on read; a same-edge event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_q <= 1'b0;
            af_q <= 1'b0;
            uf_q <= 1'b0;
        end else begin
            pf_q <= per_evt   | (pf_q & ~rd);
            af_q <= alarm_evt | (af_q & ~rd);
            uf_q <= upd_evt   | (uf_q & ~rd);
        end
    end

    // Combine masked flags into the summary bit and the request pin.
    always_comb begin
        sum   = (pf_q & pie) | (af_q & aie) | (uf_q & uie);
        flags = {sum, pf_q, af_q, uf_q};
        irq_n = ~sum;
    end

    // R8: an unread flag stays set.
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (af_q && !rd) |=> af_q);
    // R10: a read with no new event leaves every flag clear.
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !per_evt && !alarm_evt && !upd_evt) |=> (flags[2:0] == 3'b000));
    // R10: an event on the read edge is kept.
    a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        per_evt |=> pf_q);

endmodule

// File: rtl/periodic_irq_gen.sv
// Module: top of the periodic interrupt and square-wave generator.
// Assumes clk is the time-base clock; events arrive synchronous to it.
module periodic_irq_gen #(
    parameter int unsigned L_HI  = 22,
    parameter int unsigned L_MID = 20,
    parameter int unsigned L_LO  = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] base_sel,
    input  logic       div_hold,
    input  logic [3:0] rate_sel,
    input  logic       sq_en,
    input  logic       pie,
    input  logic       aie,
    input  logic       uie,
    input  logic       alarm_pulse,
    input  logic       update_pulse,
    input  logic       flag_rd,
    input  logic       ck_div4,
    output logic       sqw,
    output logic       irq_n,
    output logic [3:0] flags,
    output logic       tick_1hz,
    output logic       ckout
);
    import psq_pkg::*;

    localparam int unsigned CW = max3(L_HI, L_MID, L_LO);

    logic [CW-1:0] cnt;
    logic [5:0]    l_cur;
    logic          slow, run, per_evt;
    logic [1:0]    ck_q;

    psq_divider #(.L_HI(L_HI), .L_MID(L_MID), .L_LO(L_LO), .CW(CW)) u_div (
        .clk(clk), .rst_n(rst_n), .hold(div_hold), .base_sel(base_sel),
        .cnt(cnt), .l_cur(l_cur), .slow(slow), .run(run), .tick(tick_1hz)
    );

    psq_rate_tap #(.CW(CW)) u_tap (
        .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt), .l_cur(l_cur),
        .slow(slow), .rate_sel(rate_sel), .sq_en(sq_en),
        .per_evt(per_evt), .sqw(sqw)
    );

    psq_irq u_irq (
        .clk(clk), .rst_n(rst_n), .per_evt(per_evt), .alarm_evt(alarm_pulse),
        .upd_evt(update_pulse), .rd(flag_rd), .pie(pie), .aie(aie), .uie(uie),
        .flags(flags), .irq_n(irq_n)
    );

    // Two-bit edge counter behind the divide-by-4 clock output.
    always_ff @(posedge clk) begin
        if (!rst_n) ck_q <= 2'd0;
        else        ck_q <= ck_q + 2'd1;
    end

    // Pick the undivided or divided time base for the clock output.
    always_comb ckout = ck_div4 ? ck_q[1] : clk;

    // R11: the divide-by-4 output changes at most every second edge.
    a_r11_div4_slow: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ck_q[1]) |=> !$fell(ck_q[1]));

endmodule

// File: tb/test_periodic_irq_gen.sv
module test_periodic_irq_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] base_sel = 2'd2;
    logic div_hold = 1'b0;
    logic [3:0] rate_sel = 4'd0;
    logic sq_en = 1'b0, pie = 1'b0, aie = 1'b0, uie = 1'b0;
    logic alarm_pulse = 1'b0, update_pulse = 1'b0, flag_rd = 1'b0, ck_div4 = 1'b0;
    logic sqw, irq_n, tick_1hz, ckout;
    logic [3:0] flags;

    int checks = 0;
    int fails = 0;
    string phase = "R1";
    bit cmp_on = 1'b0;

    // Reference state
    longint pos = 0;
    bit m_tick = 0, m_sq = 0, m_pf = 0, m_af = 0, m_uf = 0;
    int m_d4 = 0;

    periodic_irq_gen i_periodic_irq_gen (
        .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .div_hold(div_hold),
        .rate_sel(rate_sel), .sq_en(sq_en), .pie(pie), .aie(aie), .uie(uie),
        .alarm_pulse(alarm_pulse), .update_pulse(update_pulse), .flag_rd(flag_rd),
        .ck_div4(ck_div4), .sqw(sqw), .irq_n(irq_n), .flags(flags),
        .tick_1hz(tick_1hz), .ckout(ckout)
    );

    always #2 clk = ~clk;

    function automatic int base_log2(logic [1:0] b);
        return (b == 2'd0) ? 22 : (b == 2'd1) ? 20 : 15;
    endfunction

    // Behavioural reference, advanced on every rising edge.
    always @(posedge clk) begin
        int l2, e;
        longint per_len;
        bit per;
        l2 = base_log2(base_sel);
        e = l2 - 16 + int'(rate_sel);
        if (l2 == 15 && rate_sel < 3) e = e + 7;
        per_len = longint'(1) << e;
        per = 1'b0;
        if (!rst_n) begin
            pos = longint'(1) << (l2 - 1);
            m_tick = 0; m_sq = 0; m_pf = 0; m_af = 0; m_uf = 0; m_d4 = 0;
        end else begin
            m_d4 = (m_d4 + 1) % 4;
            if (div_hold) begin
                pos = longint'(1) << (l2 - 1);
                m_tick = 0; m_sq = 0;
            end else begin
                pos = pos + 1;
                m_tick = (pos % (longint'(1) << l2)) == 0;
                per = (rate_sel != 0) && ((pos % per_len) == 0);
                m_sq = sq_en && (rate_sel != 0) && ((pos % per_len) >= per_len / 2);
            end
            m_pf = per | (m_pf & !flag_rd);
            m_af = alarm_pulse | (m_af & !flag_rd);
            m_uf = update_pulse | (m_uf & !flag_rd);
        end
    end

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d (phase %s) t=%0t",
                     req, what, act, exp, phase, $time);
        end
    endtask

    // Compare every output against the reference on each falling edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            bit m_sum;
            logic [3:0] m_flags;
            m_sum = (m_pf & pie) | (m_af & aie) | (m_uf & uie);
            m_flags = {m_sum, m_pf, m_af, m_uf};
            check(tick_1hz == m_tick, "R2", "tick_1hz", tick_1hz, m_tick);
            check(sqw == m_sq, "R7", "sqw", sqw, m_sq);
            check(flags[2] == m_pf, "R4", "periodic flag", flags[2], m_pf);
            check(flags[1:0] == {m_af, m_uf}, "R8", "alarm/update flags", flags[1:0], {m_af, m_uf});
            check(flags[3] == m_sum && irq_n == !m_sum, "R9", "summary/irq_n",
                  {flags[3], irq_n}, {m_sum, !m_sum});
            check(ckout == (ck_div4 ? m_d4[1] : 1'b0), "R11", "ckout low phase",
                  ckout, ck_div4 ? m_d4[1] : 1'b0);
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_evt(bit a, bit u, bit rd);
        alarm_pulse = a; update_pulse = u; flag_rd = rd;
        step(1);
        alarm_pulse = 0; update_pulse = 0; flag_rd = 0;
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired (phase %s)", phase);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        // R1: reset state
        step(3);
        check(flags == 4'd0 && irq_n && !sqw && !tick_1hz, "R1", "reset outputs",
              {flags, irq_n, sqw, tick_1hz}, 7'b0000100);
        cmp_on = 1'b1;
        rst_n = 1'b1;

        // R4/R7: fastest slow-base rate with square wave and periodic enable
        phase = "R4";
        base_sel = 2'd2; rate_sel = 4'd3; sq_en = 1; pie = 1;
        step(40);
        pulse_evt(0, 0, 1);
        step(13);
        rate_sel = 4'd6;
        step(200);

        // R3: hold, then measure the first tick after release
        phase = "R3";
        div_hold = 1; rate_sel = 4'd15;
        step(20);
        div_hold = 0;
        n = 0;
        do begin
            step(1);
            n++;
        end while (!tick_1hz && n < 20000);
        check(n == 16384, "R3", "cycles to first tick", n, 16384);
        step(40000);

        // R5: aliased codes on the slow base, then the fast bases
        phase = "R5";
        pulse_evt(0, 0, 1);
        rate_sel = 4'd1;
        step(700);
        rate_sel = 4'd2;
        step(700);
        base_sel = 2'd0; rate_sel = 4'd1;
        step(600);
        rate_sel = 4'd3;
        step(1200);
        base_sel = 2'd1; rate_sel = 4'd2;
        step(300);

        // R6: rate zero with square wave requested
        phase = "R6";
        pulse_evt(0, 0, 1);
        rate_sel = 4'd0;
        step(300);
        rate_sel = 4'd4; sq_en = 0;
        step(300);

        // R8/R9: event flags under different enables
        phase = "R8";
        base_sel = 2'd2; rate_sel = 4'd0; pie = 0;
        pulse_evt(0, 0, 1);
        pulse_evt(1, 0, 0);
        step(3);
        phase = "R9";
        aie = 1;
        step(2);
        pulse_evt(0, 1, 0);
        aie = 0;
        step(2);
        uie = 1;
        step(2);

        // R10: read clears; an event on the read edge survives
        phase = "R10";
        pulse_evt(0, 0, 1);
        check(flags == 4'd0 && irq_n, "R10", "flags after read", {flags, irq_n}, 5'b00001);
        pulse_evt(1, 0, 1);
        check(flags[1] == 1'b1, "R10", "alarm on read edge", flags[1], 1);
        pulse_evt(0, 1, 1);
        check(flags[1:0] == 2'b01, "R10", "update on read edge", flags[1:0], 1);
        step(3);

        // R11: clock output in both modes and both phases
        phase = "R11";
        ck_div4 = 0;
        step(1);
        check(ckout == 1'b1, "R11", "ckout high phase div1", ckout, 1);
        ck_div4 = 1;
        step(12);
        ck_div4 = 0;
        step(4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule